// File: doc/BRIEF.md
# Label and Source/Destination Match Filter

This block decides what happens to each word arriving from a group of serial avionics receivers. Every word arrives with its 8-bit label, its 2-bit source/destination (SD) code and the number of the receive channel that delivered it. A host-written table of filter entries is searched for the first entry that accepts the word. When an entry accepts it, the block reports the index of that entry, which the downstream store uses directly as the word's RAM address. It also reports whether the word should be copied into that channel's FIFO and which general-purpose interrupt, if any, to raise. When no entry accepts the word, the block reports a miss and the word is dropped.

Each entry is 16 bits wide:

| Bits | Meaning |
|------|---------|
| 15:14 | interrupt selector; 00 means no interrupt |
| 13:12 | channel number |
| 11 | copy the word to the channel FIFO |
| 10 | accept any SD code |
| 9:8 | SD code |
| 7:0 | label; 0 accepts any label |

A per-channel all-call enable makes a received SD code of 00 pass the SD test on that channel. Searching takes one table entry per clock, starting at index 0. One further word can wait in a holding register while a search runs.

Top module: `label_match_engine`

## Requirements
- R1: After reset, `busy` and `res_valid` are low and every table entry reads as zero. An all-zero entry therefore accepts any label with SD 00 on channel 0.
- R2: The label test passes when entry bits 7:0 equal the word's label, or when entry bits 7:0 are zero.
- R3: The SD test passes when entry bits 9:8 equal the word's SD code, or when entry bit 10 is 1.
- R4: When `allcall_en[c]` is 1 at the edge where a word from channel c is accepted, a word carrying SD code 00 passes the SD test against any entry. When that bit is 0, all-call gives no such pass.
- R5: An entry accepts a word only when entry bits 13:12 equal the word's channel number, and its label and SD tests also pass.
- R6: The reported hit is the lowest-indexed accepting entry, and `res_index` carries that index.
- R7: On a hit, `res_fifo` equals entry bit 11 and `res_irq` equals entry bits 15:14. On a miss, `res_hit`, `res_fifo`, `res_irq` and `res_index` are all 0.
- R8: `res_valid` is a one-cycle strobe. Counting the edge that accepts a word on an idle block as edge 0, a hit on entry j is reported at edge j+2 and a miss at edge N_ENTRY+1.
- R9: `busy` is high exactly while the holding register holds a word. A word offered while `busy` is high is ignored. Accepted words are reported in arrival order.
- R10: With `host_we` high, `host_wdata` is written into entry `host_addr` at the clock edge, and every later search uses the new content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| host_we | input | 1 | table write strobe |
| host_addr | input | IDX_W | table entry to write |
| host_wdata | input | 16 | entry content |
| allcall_en | input | N_CHAN | per-channel all-call enable |
| in_valid | input | 1 | incoming word present |
| in_label | input | 8 | label of incoming word |
| in_sd | input | 2 | SD code of incoming word |
| in_chan | input | 2 | receiving channel number |
| busy | output | 1 | holding register occupied; new words ignored |
| res_valid | output | 1 | one-cycle result strobe |
| res_hit | output | 1 | an entry accepted the word |
| res_index | output | IDX_W | index of accepting entry |
| res_fifo | output | 1 | copy word to channel FIFO |
| res_irq | output | 2 | interrupt selector |

## Verification
The bench builds the block with its defaults: 128 entries and 4 channels. These values reach both ends of the search. A hit on entry 0 comes two edges after acceptance, and a hit on entry 127 or a miss takes the full 129-edge search, so the latency checks cover both ends of the index range. With 4 channels, every code of the 2-bit channel field is live, so channel mismatches and per-channel all-call enables can both be exercised on the same table.

// File: rtl/lm_pkg.sv
package lm_pkg;

    localparam int LBL_W  = 8;
    localparam int SD_W   = 2;
    localparam int CH_W   = 2;
    localparam int ENT_W  = 16;

    // bit layout decoded by the downstream store and interrupt logic
    typedef struct packed {
        logic [1:0]       irq;
        logic [CH_W-1:0]  chan;
        logic             to_fifo;
        logic             sd_any;
        logic [SD_W-1:0]  sd;
        logic [LBL_W-1:0] label;
    } entry_t;

    typedef struct packed {
        logic [LBL_W-1:0] label;
        logic [SD_W-1:0]  sd;
        logic [CH_W-1:0]  chan;
        logic             all_call;
    } rxword_t;

    function automatic logic entry_hits(entry_t e, rxword_t w);
        logic lbl_ok, sd_ok, ch_ok;
        lbl_ok = (e.label == '0) || (e.label == w.label);
        sd_ok  = e.sd_any || (e.sd == w.sd) || (w.all_call && (w.sd == '0));
        ch_ok  = (e.chan == w.chan);
        return lbl_ok && sd_ok && ch_ok;
    endfunction

endpackage

// File: rtl/lm_table.sv
module lm_table
    import lm_pkg::*;
#(
    parameter int N_ENTRY = 128,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output entry_t           rdata
);
    logic [ENT_W-1:0] mem [N_ENTRY];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRY; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = entry_t'(mem[raddr]);
endmodule

// File: rtl/lm_inbuf.sv
module lm_inbuf
    import lm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  rxword_t in_word,
    input  logic    take,
    output logic    full,
    output rxword_t word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (!full) begin
            if (in_valid) begin
                full <= 1'b1;
                word <= in_word;
            end
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R9
    accept_fills_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !full) |=> full);

    // R9
    held_word_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(word)));
endmodule

// File: rtl/lm_scanner.sv
module lm_scanner
    import lm_pkg::*;
#(
    parameter int N_ENTRY = 128,
    localparam int IDX_W  = $clog2(N_ENTRY),
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRY - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_ready,
    input  rxword_t          word_in,
    output logic             take,
    input  entry_t           entry,
    output logic [IDX_W-1:0] idx,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_index,
    output logic             res_fifo,
    output logic [1:0]       res_irq
);
    logic    scanning;
    rxword_t cur;
    logic    hit_now;

    assign take    = word_ready && !scanning;
    assign hit_now = entry_hits(entry, cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            scanning  <= 1'b0;
            idx       <= '0;
            cur       <= '0;
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_index <= '0;
            res_fifo  <= 1'b0;
            res_irq   <= '0;
        end else begin
            res_valid <= 1'b0;
            if (!scanning) begin
                if (take) begin
                    scanning <= 1'b1;
                    idx      <= '0;
                    cur      <= word_in;
                end
            end else if (hit_now) begin
                scanning  <= 1'b0;
                res_valid <= 1'b1;
                res_hit   <= 1'b1;
                res_index <= idx;
                res_fifo  <= entry.to_fifo;
                res_irq   <= entry.irq;
            end else if (idx == LAST) begin
                scanning  <= 1'b0;
                res_valid <= 1'b1;
                res_hit   <= 1'b0;
                res_index <= '0;
                res_fifo  <= 1'b0;
                res_irq   <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R6
    scan_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scanning) |-> (idx == '0));

    // R8
    result_after_scan_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !scanning);

    // R7
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (!res_fifo && res_irq == 2'b00 && res_index == '0));
endmodule

// File: rtl/label_match_engine.sv
module label_match_engine
    import lm_pkg::*;
#(
    parameter int N_ENTRY = 128,
    parameter int N_CHAN  = 4,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [15:0]       host_wdata,
    input  logic [N_CHAN-1:0] allcall_en,
    input  logic              in_valid,
    input  logic [7:0]        in_label,
    input  logic [1:0]        in_sd,
    input  logic [1:0]        in_chan,
    output logic              busy,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_index,
    output logic              res_fifo,
    output logic [1:0]        res_irq
);
    rxword_t          in_word, held;
    logic             take;
    logic [IDX_W-1:0] scan_idx;
    entry_t           cur_entry;

    always_comb begin
        in_word.label    = in_label;
        in_word.sd       = in_sd;
        in_word.chan     = in_chan;
        in_word.all_call = allcall_en[in_chan];
    end

    lm_table #(.N_ENTRY(N_ENTRY)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (host_we),
        .waddr (host_addr),
        .wdata (host_wdata),
        .raddr (scan_idx),
        .rdata (cur_entry)
    );

    lm_inbuf u_inbuf (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_word  (in_word),
        .take     (take),
        .full     (busy),
        .word     (held)
    );

    lm_scanner #(.N_ENTRY(N_ENTRY)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .word_ready (busy),
        .word_in    (held),
        .take       (take),
        .entry      (cur_entry),
        .idx        (scan_idx),
        .res_valid  (res_valid),
        .res_hit    (res_hit),
        .res_index  (res_index),
        .res_fifo   (res_fifo),
        .res_irq    (res_irq)
    );
endmodule

// File: tb/sim_label_match_engine.sv
module sim_label_match_engine;
    localparam int N  = 128;
    localparam int NC = 4;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_we = 1'b0;
    logic [IW-1:0] host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [NC-1:0] allcall_en = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_label = '0;
    logic [1:0]    in_sd = '0;
    logic [1:0]    in_chan = '0;
    logic          busy, res_valid, res_hit, res_fifo;
    logic [IW-1:0] res_index;
    logic [1:0]    res_irq;

    int vecs = 0;
    int fails = 0;
    logic [15:0] tbl [N];

    always #10 clk = ~clk;

    label_match_engine #(.N_ENTRY(N), .N_CHAN(NC)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .allcall_en(allcall_en), .in_valid(in_valid),
        .in_label(in_label), .in_sd(in_sd), .in_chan(in_chan), .busy(busy),
        .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index),
        .res_fifo(res_fifo), .res_irq(res_irq)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model(input logic [7:0] l, input logic [1:0] s,
                                 input logic [1:0] c, input logic ac);
        for (int i = 0; i < N; i++) begin
            logic lo, so, co;
            lo = (tbl[i][7:0] == 8'd0) || (tbl[i][7:0] == l);
            so = tbl[i][10] || (tbl[i][9:8] == s) || (ac && s == 2'b00);
            co = (tbl[i][13:12] == c);
            if (lo && so && co) return i;
        end
        return -1;
    endfunction

    task automatic host_write(input int a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = IW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        tbl[a] = d;
    endtask

    function automatic logic [15:0] mk(input logic [1:0] irq, input logic [1:0] ch,
                                       input logic f, input logic any,
                                       input logic [1:0] sd, input logic [7:0] lb);
        return {irq, ch, f, any, sd, lb};
    endfunction

    task automatic send(input logic [7:0] l, input logic [1:0] s,
                        input logic [1:0] c, input string req);
        int e, cyc, lat;
        logic got;
        e = model(l, s, c, allcall_en[c]);
        @(negedge clk);
        in_valid = 1'b1; in_label = l; in_sd = s; in_chan = c;
        @(posedge clk);
        got = 1'b0; cyc = 0;
        for (int k = 1; k <= N + 10; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (res_valid) begin got = 1'b1; cyc = k; break; end
        end
        chk(got, req, "no result strobe", 0, 1);
        if (!got) return;
        lat = (e < 0) ? N + 2 : e + 3;
        chk(cyc == lat, "R8", "latency", cyc, lat);
        chk(res_hit == (e >= 0), req, "hit flag", int'(res_hit), int'(e >= 0));
        if (e >= 0) begin
            chk(res_index == IW'(e), "R6", "index", int'(res_index), e);
            chk(res_fifo == tbl[e][11], "R7", "fifo flag", int'(res_fifo), int'(tbl[e][11]));
            chk(res_irq == tbl[e][15:14], "R7", "irq select", int'(res_irq), int'(tbl[e][15:14]));
        end else begin
            chk(res_fifo == 1'b0 && res_irq == 2'b00 && res_index == '0, "R7",
                "miss fields", int'({res_index, res_fifo, res_irq}), 0);
        end
        @(negedge clk);
        chk(!res_valid, "R8", "strobe width", int'(res_valid), 0);
    endtask

    // result recorder for the ordering test
    logic collect = 1'b0;
    int   nres = 0;
    int   rec [8];
    always @(negedge clk) begin
        if (collect && res_valid) begin
            if (nres < 8) rec[nres] = res_hit ? int'(res_index) : -1;
            nres++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < N; i++) tbl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        chk(!busy, "R1", "busy after reset", int'(busy), 0);
        chk(!res_valid, "R1", "res_valid after reset", int'(res_valid), 0);
        send(8'h55, 2'b00, 2'd0, "R1");   // zero table: entry 0 takes it
        send(8'h55, 2'b01, 2'd0, "R1");   // zero table: SD 01 misses

        // fill table with random entries, labels 1..6
        for (int i = 0; i < N; i++)
            host_write(i, mk(2'($urandom), 2'($urandom), 1'($urandom),
                             ($urandom % 8) == 0, 2'($urandom),
                             8'(1 + $urandom % 6)));
        host_write(127, mk(2'd3, 2'd3, 1'b1, 1'b1, 2'd0, 8'h00));
        host_write(100, mk(2'd2, 2'd1, 1'b1, 1'b0, 2'd2, 8'hC8));
        host_write(50,  mk(2'd1, 2'd0, 1'b0, 1'b1, 2'd3, 8'hD0));

        send(8'hEE, 2'd1, 2'd3, "R2");    // label wildcard, last entry
        send(8'hC8, 2'd2, 2'd1, "R2");    // exact label
        send(8'hC8, 2'd1, 2'd1, "R3");    // SD mismatch -> miss
        send(8'hD0, 2'd1, 2'd0, "R3");    // bit 10 SD wildcard
        send(8'hC8, 2'd0, 2'd1, "R4");    // all-call off -> miss
        @(negedge clk); allcall_en = 4'b0010;
        send(8'hC8, 2'd0, 2'd1, "R4");    // all-call on -> hit 100
        @(negedge clk); allcall_en = 4'b0000;
        send(8'hC8, 2'd2, 2'd2, "R5");    // wrong channel -> miss
        host_write(10, mk(2'd0, 2'd1, 1'b0, 1'b0, 2'd2, 8'hC8));
        send(8'hC8, 2'd2, 2'd1, "R10");   // new entry wins as lowest

        for (int n = 0; n < 60; n++) begin
            logic [7:0] l;
            @(negedge clk); allcall_en = 4'($urandom);
            l = (($urandom % 5) == 0) ? 8'hC8 : 8'(1 + $urandom % 6);
            send(l, 2'($urandom), 2'($urandom), "R6");
        end
        @(negedge clk); allcall_en = 4'b0000;

        // R9 holding register, ignore while busy, ordering
        collect = 1'b1; nres = 0;
        @(negedge clk);
        in_valid = 1'b1; in_label = 8'hEE; in_sd = 2'd1; in_chan = 2'd3;      // A -> 127
        @(posedge clk);
        @(negedge clk);
        chk(busy, "R9", "busy while word held", int'(busy), 1);
        in_label = 8'hC8; in_sd = 2'd2; in_chan = 2'd1;                        // C ignored
        @(posedge clk);
        @(negedge clk);
        chk(!busy, "R9", "busy clear after handoff", int'(busy), 0);
        in_label = 8'hD0; in_sd = 2'd1; in_chan = 2'd0;                        // B -> 50
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(busy, "R9", "busy with second word", int'(busy), 1);
        repeat (3 * N) @(negedge clk);
        collect = 1'b0;
        chk(nres == 2, "R9", "result count", nres, 2);
        chk(rec[0] == 127, "R9", "first result index", rec[0], 127);
        chk(rec[1] == 50, "R9", "second result index", rec[1], 50);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule